// File: doc/BRIEF.md
# Hint-Driven Clock Gating Controller

This block computes the enable inputs of the clock-gate cells for two groups of clocks. Peripheral clocks are switched straight from a software enable register. Each one is also qualified by the clock-enable input of the power domain that it belongs to. Transactional-unit clocks follow a software hint register. A cleared hint only takes effect once the unit reports idle, so a busy unit keeps its clock. A scan-mode input forces every gated clock on.

The block also has a read-only hint-status register that shows the hint state the gates actually apply. It drives three domain status outputs that follow the power-manager clock enables. It drives a jitter-enable output from a one-bit control register. Software reaches the registers through a simple word-addressed write strobe and a combinational read port.

Top module: `hint_clk_gate_ctrl`

## Requirements
- R1: After reset every peripheral enable and hint bit reads as 1, the hint status reads all ones and the jitter output is 0.
- R2: A peripheral clock enable is the AND of its enable-register bit (offset 0, bit i) and the clock enable of its domain. With the defaults, peripherals 0 and 2 use the io domain (input bit 0), peripheral 1 uses usb (bit 2) and peripheral 3 uses main (bit 1). The result appears two clock edges after a register write or one edge after an input change.
- R3: While scan mode is high, every peripheral and transactional clock enable is 1 in the same cycle.
- R4: A transactional clock whose unit is busy (idle input 0) stays enabled even when its hint bit is 0.
- R5: A transactional clock is disabled when its hint bit is 0 and its unit is idle.
- R6: A hint bit of 1 (offset 1, bit i) enables its transactional clock whatever the idle input.
- R7: When the main-domain clock enable (bit 1) is low, every transactional clock is disabled unless scan mode is high.
- R8: The hint status at offset 2 reads, per unit, the hint bit OR the inverted idle input, registered one edge behind.
- R9: Writes to offset 2 are ignored.
- R10: Each domain status output bit equals its domain clock-enable input one edge later.
- R11: The jitter output equals bit 0 of the last data written to offset 3.
- R12: Reads of offsets 0, 1 and 3 return the stored bits, and all bits above the field read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| scan_en_i | input | 1 | Scan mode, forces all gated clocks on |
| dom_clk_en_i | input | 3 | Power-manager clock enables: bit0 io, bit1 main, bit2 usb |
| idle_i | input | NUM_TRANS | Per-unit idle indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register word offset for writes |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Register word offset for reads |
| rd_data_o | output | DATA_W | Read data (combinational) |
| peri_clk_en_o | output | NUM_PERI | Peripheral clock-gate enables |
| trans_clk_en_o | output | NUM_TRANS | Transactional clock-gate enables |
| dom_status_o | output | 3 | Domain clock status, follows dom_clk_en_i |
| jitter_en_o | output | 1 | Jitter enable |

## Verification
The bench clears hints while units are busy. A design that gated on the hint alone would stop a busy unit's clock and report a cleared status. It drops each domain enable in turn to expose a wrong peripheral-to-domain mapping, and it drops the main enable to confirm that transactional clocks fall even when hints are set. It also raises scan mode during those off states to catch a missing override, and it writes to the status offset and writes jitter data with only upper bits set, which would catch a writable status register or a jitter bit taken from the wrong position.

// File: rtl/cg_pkg.sv
// Package: shared constants of the clock gating controller.
// Assumes a 2-bit word offset space and three power domains.
package cg_pkg;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned NUM_DOM   = 3;
    localparam logic [ADDR_W-1:0] OFS_PERI = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_HINT = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_JIT  = 2'd3;
    localparam int unsigned DOM_IO   = 0;
    localparam int unsigned DOM_MAIN = 1;
    localparam int unsigned DOM_USB  = 2;
endpackage

// File: rtl/cg_regfile.sv
// Module: software register file of the gating controller.
// Holds peripheral enables, hints and jitter enable; status is an input
// from the transactional gate and is read-only. Assumes field widths <= DATA_W.
module cg_regfile
    import cg_pkg::*;
#(
    parameter int unsigned NUM_PERI  = 4,
    parameter int unsigned NUM_TRANS = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    input  logic [NUM_TRANS-1:0] status_i,
    output logic [NUM_PERI-1:0]  peri_q_o,
    output logic [NUM_TRANS-1:0] hint_q_o,
    output logic                 jit_q_o
);
    logic wr_peri, wr_hint, wr_jit;

    // Decode which writable register a strobe targets.
    always_comb begin
        wr_peri = wr_en_i && (wr_addr_i == OFS_PERI);
        wr_hint = wr_en_i && (wr_addr_i == OFS_HINT);
        wr_jit  = wr_en_i && (wr_addr_i == OFS_JIT);
    end

    // Store peripheral enables; all on after reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      peri_q_o <= '1;
        else if (wr_peri) peri_q_o <= wr_data_i[NUM_PERI-1:0];
    end

    // Store hints; all set after reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      hint_q_o <= '1;
        else if (wr_hint) hint_q_o <= wr_data_i[NUM_TRANS-1:0];
    end

    // Store jitter enable; off after reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     jit_q_o <= 1'b0;
        else if (wr_jit) jit_q_o <= wr_data_i[0];
    end

    // Return the addressed register, zero-extended.
    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            OFS_PERI: rd_data_o[NUM_PERI-1:0]  = peri_q_o;
            OFS_HINT: rd_data_o[NUM_TRANS-1:0] = hint_q_o;
            OFS_STAT: rd_data_o[NUM_TRANS-1:0] = status_i;
            default:  rd_data_o[0]             = jit_q_o;
        endcase
    end

    // R11
    jit_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == OFS_JIT) |=> (jit_q_o == $past(wr_data_i[0])));

    // R9
    stat_no_side_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == OFS_STAT) |=> ($stable(peri_q_o) && $stable(hint_q_o) && $stable(jit_q_o)));
endmodule

// File: rtl/cg_peri_gate.sv
// Module: peripheral clock enables.
// Each peripheral takes its register bit ANDed with the enable of its
// power domain (chosen by PERI_DOM_MAP, 2 bits per peripheral), registered.
// Scan mode overrides the registered value combinationally.
module cg_peri_gate
    import cg_pkg::*;
#(
    parameter int unsigned NUM_PERI = 4,
    parameter logic [2*NUM_PERI-1:0] PERI_DOM_MAP = 8'b01_00_10_00
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 scan_en_i,
    input  logic [NUM_DOM-1:0]   dom_clk_en_i,
    input  logic [NUM_PERI-1:0]  peri_q_i,
    output logic [NUM_PERI-1:0]  peri_clk_en_o
);
    logic [NUM_PERI-1:0] dom_sel;
    logic [NUM_PERI-1:0] en_q;

    for (genvar i = 0; i < NUM_PERI; i++) begin : g_peri
        localparam int unsigned DIDX = int'(PERI_DOM_MAP[2*i +: 2]);

        // Pick the domain enable that qualifies this peripheral.
        always_comb dom_sel[i] = dom_clk_en_i[DIDX];

        // Register the qualified enable; on after reset.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) en_q[i] <= 1'b1;
            else         en_q[i] <= peri_q_i[i] & dom_sel[i];
        end

        // R2
        peri_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!peri_q_i[i] || !dom_clk_en_i[DIDX]) |=> (!en_q[i]));
    end

    // Apply the scan override.
    always_comb peri_clk_en_o = en_q | {NUM_PERI{scan_en_i}};
endmodule

// File: rtl/cg_trans_gate.sv
// Module: transactional-unit clock enables and hint status.
// A unit's clock runs while its hint is set or it is busy, and only when
// the main domain is enabled; scan overrides combinationally.
module cg_trans_gate #(
    parameter int unsigned NUM_TRANS = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 scan_en_i,
    input  logic                 main_en_i,
    input  logic [NUM_TRANS-1:0] hint_q_i,
    input  logic [NUM_TRANS-1:0] idle_i,
    output logic [NUM_TRANS-1:0] trans_clk_en_o,
    output logic [NUM_TRANS-1:0] hint_status_o
);
    logic [NUM_TRANS-1:0] want_on;
    logic [NUM_TRANS-1:0] en_q;

    // A unit needs its clock when hinted on or still busy.
    always_comb want_on = hint_q_i | ~idle_i;

    // Register the gate enables, masked by the main domain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) en_q <= '1;
        else         en_q <= want_on & {NUM_TRANS{main_en_i}};
    end

    // Register the effective hint state for readback.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) hint_status_o <= '1;
        else         hint_status_o <= want_on;
    end

    // Apply the scan override.
    always_comb trans_clk_en_o = en_q | {NUM_TRANS{scan_en_i}};

    for (genvar i = 0; i < NUM_TRANS; i++) begin : g_chk
        // R4
        busy_keeps_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (main_en_i && !idle_i[i]) |=> en_q[i]);
        // R5
        idle_clear_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!hint_q_i[i] && idle_i[i]) |=> !en_q[i]);
        // R6
        hint_starts_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (main_en_i && hint_q_i[i]) |=> en_q[i]);
    end

    // R7
    main_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !main_en_i |=> (en_q == '0));
endmodule

// File: rtl/hint_clk_gate_ctrl.sv
// Module: top of the hint-driven clock gating controller.
// Ties the register file to the peripheral and transactional gates and
// registers the per-domain status outputs. Synchronous active-low reset.
module hint_clk_gate_ctrl
    import cg_pkg::*;
#(
    parameter int unsigned NUM_PERI  = 4,
    parameter int unsigned NUM_TRANS = 4,
    parameter int unsigned DATA_W    = 32,
    parameter logic [2*NUM_PERI-1:0] PERI_DOM_MAP = 8'b01_00_10_00
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 scan_en_i,
    input  logic [2:0]           dom_clk_en_i,
    input  logic [NUM_TRANS-1:0] idle_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [1:0]           rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic [NUM_PERI-1:0]  peri_clk_en_o,
    output logic [NUM_TRANS-1:0] trans_clk_en_o,
    output logic [2:0]           dom_status_o,
    output logic                 jitter_en_o
);
    logic [NUM_PERI-1:0]  peri_q;
    logic [NUM_TRANS-1:0] hint_q;
    logic [NUM_TRANS-1:0] hint_status;
    logic                 jit_q;

    cg_regfile #(
        .NUM_PERI (NUM_PERI),
        .NUM_TRANS(NUM_TRANS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o),
        .status_i (hint_status),
        .peri_q_o (peri_q),
        .hint_q_o (hint_q),
        .jit_q_o  (jit_q)
    );

    cg_peri_gate #(
        .NUM_PERI    (NUM_PERI),
        .PERI_DOM_MAP(PERI_DOM_MAP)
    ) u_peri (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .scan_en_i    (scan_en_i),
        .dom_clk_en_i (dom_clk_en_i),
        .peri_q_i     (peri_q),
        .peri_clk_en_o(peri_clk_en_o)
    );

    cg_trans_gate #(
        .NUM_TRANS(NUM_TRANS)
    ) u_trans (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .scan_en_i     (scan_en_i),
        .main_en_i     (dom_clk_en_i[DOM_MAIN]),
        .hint_q_i      (hint_q),
        .idle_i        (idle_i),
        .trans_clk_en_o(trans_clk_en_o),
        .hint_status_o (hint_status)
    );

    // Track the power-manager enables one edge behind.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) dom_status_o <= '0;
        else         dom_status_o <= dom_clk_en_i;
    end

    // Drive the jitter output from its register.
    always_comb jitter_en_o = jit_q;

    // R10
    dom_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dom_status_o == $past(dom_clk_en_i)));

    // R3
    scan_forces_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_en_i |-> ((&peri_clk_en_o) && (&trans_clk_en_o)));
endmodule

// File: tb/hint_clk_gate_ctrl_tb.sv
// Scoreboard bench: the driver applies stimulus, updates a requirement model
// and pushes the expected state; the monitor pops and compares at negedge.
module hint_clk_gate_ctrl_tb;
    localparam int unsigned NP = 4;
    localparam int unsigned NT = 4;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan = 1'b0;
    logic [2:0]    dom = 3'b111;
    logic [NT-1:0] idle = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NP-1:0] peri_en;
    logic [NT-1:0] trans_en;
    logic [2:0]    dom_stat;
    logic          jit;

    hint_clk_gate_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan), .dom_clk_en_i(dom),
        .idle_i(idle), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .peri_clk_en_o(peri_en),
        .trans_clk_en_o(trans_en), .dom_status_o(dom_stat), .jitter_en_o(jit)
    );

    always #2 clk = ~clk;

    typedef struct {
        string         req;
        logic [NP-1:0] peri;
        logic [NT-1:0] trans;
        logic [2:0]    dstat;
        logic          jitter;
        logic [1:0]    raddr;
        logic [DW-1:0] rdata;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Requirement model state.
    logic [NP-1:0] m_peri = '1;
    logic [NT-1:0] m_hint = '1;
    logic          m_jit  = 1'b0;

    function automatic logic [NP-1:0] dom_mask(input logic [2:0] d);
        // peri0,2 -> io(bit0), peri1 -> usb(bit2), peri3 -> main(bit1)
        return {d[1], d[0], d[2], d[0]};
    endfunction

    function automatic logic [DW-1:0] reg_val(input logic [1:0] a);
        logic [DW-1:0] v = '0;
        case (a)
            2'd0: v[NP-1:0] = m_peri;
            2'd1: v[NT-1:0] = m_hint;
            2'd2: v[NT-1:0] = m_hint | ~idle;
            default: v[0] = m_jit;
        endcase
        return v;
    endfunction

    task automatic expect_now(input string req, input logic [1:0] ra);
        exp_t e;
        e.req    = req;
        e.peri   = scan ? '1 : (m_peri & dom_mask(dom));
        e.trans  = scan ? '1 : ((m_hint | ~idle) & {NT{dom[1]}});
        e.dstat  = dom;
        e.jitter = m_jit;
        e.raddr  = ra;
        e.rdata  = reg_val(ra);
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        @(posedge clk); @(posedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_peri = d[NP-1:0];
            2'd1: m_hint = d[NT-1:0];
            2'd3: m_jit  = d[0];
            default: ;
        endcase
        settle();
    endtask

    task automatic set_inputs(input logic s, input logic [2:0] d, input logic [NT-1:0] id);
        @(negedge clk);
        scan = s; dom = d; idle = id;
        settle();
    endtask

    task automatic cmp(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop the next expected item and compare against the outputs.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            rd_addr = e.raddr;
            #0.5;
            cmp(e.req, "peri_clk_en", DW'(peri_en), DW'(e.peri));
            cmp(e.req, "trans_clk_en", DW'(trans_en), DW'(e.trans));
            cmp(e.req, "dom_status", DW'(dom_stat), DW'(e.dstat));
            cmp(e.req, "jitter_en", DW'(jit), DW'(e.jitter));
            cmp(e.req, "rd_data", rd_data, e.rdata);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle();
        // R1 reset values
        expect_now("R1", 2'd0);
        expect_now("R1", 2'd2);
        expect_now("R1", 2'd3);
        // R2 peripheral enables from register
        write_reg(2'd0, 32'h5);
        expect_now("R2", 2'd0);
        write_reg(2'd0, 32'hF);
        // R2 io domain off drops peri0 and peri2; R10 status follows
        set_inputs(1'b0, 3'b110, '0);
        expect_now("R2_R10", 2'd0);
        // R2 usb domain off drops peri1
        set_inputs(1'b0, 3'b011, '0);
        expect_now("R2_R10", 2'd0);
        // R3 scan forces all on
        set_inputs(1'b1, 3'b000, '1);
        expect_now("R3", 2'd0);
        set_inputs(1'b0, 3'b111, '0);
        // R4 busy units keep clocks with hints cleared; R8 status
        write_reg(2'd1, 32'h0);
        expect_now("R4_R8", 2'd2);
        // R5 idle and cleared stops clocks
        set_inputs(1'b0, 3'b111, 4'b0011);
        expect_now("R5_R8", 2'd2);
        set_inputs(1'b0, 3'b111, 4'b1111);
        expect_now("R5_R8", 2'd2);
        // R6 set hint enables regardless of idle
        write_reg(2'd1, 32'h9);
        expect_now("R6", 2'd1);
        // R7 main off kills transactional clocks
        set_inputs(1'b0, 3'b101, 4'b0000);
        expect_now("R7", 2'd2);
        // R7 scan overrides main off
        set_inputs(1'b1, 3'b101, 4'b0000);
        expect_now("R7_R3", 2'd2);
        set_inputs(1'b0, 3'b111, 4'b1111);
        // R9 write to status ignored
        write_reg(2'd2, 32'h0);
        expect_now("R9", 2'd2);
        expect_now("R9", 2'd1);
        // R11 jitter follows bit 0
        write_reg(2'd3, 32'h1);
        expect_now("R11", 2'd3);
        write_reg(2'd3, 32'hFFFF_FFFE);
        expect_now("R11", 2'd3);
        // R12 upper bits read as zero
        write_reg(2'd1, 32'hFFFF_FFF6);
        expect_now("R12", 2'd1);
        write_reg(2'd0, 32'hABCD_0003);
        expect_now("R12", 2'd0);
        repeat (3) @(negedge clk);
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule